// File: doc/BRIEF.md
# Double to Integer Converter

This block turns the bit pattern of a 64-bit IEEE double into a 64-bit two's-complement integer. The caller picks one of four rounding directions, or forces chopping toward zero with a separate override. Values too large to fit are not clamped. The low 64 bits of the exact integer are delivered, together with an integer-overflow flag. A caller that wants an unsigned conversion can therefore use the same result. The single pattern equal to -2^63 fits exactly and raises no flag.

Each accepted operand gives one result one or two clock cycles later. The latency is chosen by the `STAGES` parameter. The result and three flags (invalid operand, integer overflow, inexact) come out together with a done strobe. A flush control chooses how subnormal inputs are treated. When it is set they become zero quietly. When it is clear they are treated as tiny nonzero values and rounded.

Top module: `dbl2int_conv`

## Requirements
- R1: An operand whose 11-bit exponent field (bits 62:52) is all ones gives result 0, sets invalid, and clears overflow and inexact.
- R2: An operand with a zero exponent field, a nonzero fraction and flush clear is rounded as a value below one ulp of the integer grid. Inexact is set. The result is +1 only when rounding up a positive operand, -1 only when rounding down a negative operand, and 0 in every other case.
- R3: With flush set, a zero-exponent operand gives result 0 and no flags. A true zero (zero exponent and zero fraction) gives 0 and no flags whatever the flush setting.
- R4: With the hidden bit restored and k = exponent − 1075 ≥ 0, the result is the 53-bit significand shifted left by k, taken modulo 2^64. For k ≥ 64 the result is 0. The sign then applies as in R9.
- R5: Overflow and inexact are both set when k ≥ 11, except for the exact operand 0xC3E0000000000000. That operand gives 0x8000000000000000 with no flags. For 0 ≤ k < 11 no flag is set.
- R6: For k < 0 the magnitude is the significand shifted right by −k. The dropped bits form a remainder: they are left-aligned when −k < 63, and a single sticky bit is used otherwise. Any nonzero remainder sets inexact.
- R7: Rounding mode 2 is nearest-even. It adds 1 to the magnitude when the remainder exceeds one half. At exactly one half it adds the magnitude's low bit.
- R8: Mode 0 truncates toward zero. Mode 3 rounds toward +infinity and adds 1 only for positive operands with a remainder. Mode 1 rounds toward −infinity and adds 1 to the magnitude only for negative operands with a remainder.
- R9: A set sign bit (bit 63) yields the two's-complement negation of the rounded magnitude.
- R10: The chop input forces mode 0 whatever the mode input is.
- R11: out_valid rises exactly STAGES cycles after an accepted in_valid. Result and flags are valid in that same cycle and hold while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Double-precision bit pattern |
| in_rmode | input | 2 | Rounding mode: 0 zero, 1 down, 2 nearest-even, 3 up |
| in_chop | input | 1 | Force rounding toward zero |
| in_ftz | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Done strobe |
| out_result | output | 64 | Two's-complement integer, modulo 2^64 |
| out_invalid | output | 1 | Operand was NaN or infinity |
| out_iovf | output | 1 | Integer did not fit in 64 signed bits |
| out_inexact | output | 1 | Result differs from the operand value |

## Verification
Directed patterns cover several cases, each aimed at one part of the logic. The ±2.5, 3.5, 0.5 and 1.5 cases separate the four rounding directions and both sides of the ties-to-even rule. Subnormals with flush on and off, plus the smallest normal, tell the sticky path apart from the silent zero. The values 2^52, 2^63, −2^63 and 2^64 probe where exact left shifts end, where overflow begins with its single exception, and where the result wraps to zero. NaN and infinity isolate the invalid path. Random operands then sweep exponents on both sides of the binary point in every mode, with chop and flush toggled, and are compared with a bench model. A single-operand trace checks the done latency.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;

   typedef enum logic [1:0] {
      RND_ZERO = 2'd0,
      RND_DOWN = 2'd1,
      RND_NEAR = 2'd2,
      RND_UP   = 2'd3
   } rnd_mode_e;

   function automatic rnd_mode_e pick_mode(input logic [1:0] raw, input logic chop);
      return chop ? RND_ZERO : rnd_mode_e'(raw);
   endfunction

endpackage

// File: rtl/dbl2int_align.sv
module dbl2int_align #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 64
) (
   input  logic [EXP_W+FRAC_W:0] op,
   input  logic                  ftz,
   output logic [INT_W-1:0]      mag,
   output logic [INT_W-1:0]      rem,
   output logic                  neg,
   output logic                  invalid,
   output logic                  iovf
);
   localparam int OP_W    = 1 + EXP_W + FRAC_W;
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int OFFS    = BIAS + FRAC_W;
   localparam int SH_W    = EXP_W + 2;
   localparam int IDX_W   = $clog2(INT_W);
   localparam int OVF_SH  = INT_W - 1 - FRAC_W;
   localparam int MIN_EXP = BIAS + INT_W - 1;
   localparam int PAD_W   = INT_W - FRAC_W - 1;

   logic [EXP_W-1:0]      exp_f;
   logic [FRAC_W-1:0]     frac_f;
   logic [INT_W-1:0]      sig;
   logic signed [SH_W-1:0] shift;
   logic signed [SH_W-1:0] rshamt;
   logic [2*INT_W-1:0]    wide;
   logic                  is_min_neg;

   always_comb begin
      exp_f      = op[OP_W-2 -: EXP_W];
      frac_f     = op[FRAC_W-1:0];
      neg        = op[OP_W-1];
      sig        = {{PAD_W{1'b0}}, 1'b1, frac_f};
      shift      = $signed({2'b00, exp_f}) - $signed(SH_W'(OFFS));
      rshamt     = -shift;
      wide       = {sig, {INT_W{1'b0}}} >> $unsigned(rshamt);
      is_min_neg = neg && (exp_f == EXP_W'(MIN_EXP)) && (frac_f == '0);
      mag        = '0;
      rem        = '0;
      invalid    = 1'b0;
      iovf       = 1'b0;
      if (exp_f == '0) begin
         if ((frac_f != '0) && !ftz) rem = INT_W'(1);
      end else if (exp_f == '1) begin
         invalid = 1'b1;
      end else if (!shift[SH_W-1]) begin
         if (shift < SH_W'(INT_W)) mag = sig << shift[IDX_W-1:0];
         if ((shift >= SH_W'(OVF_SH)) && !is_min_neg) iovf = 1'b1;
      end else begin
         if (rshamt < SH_W'(INT_W - 1)) begin
            mag = wide[2*INT_W-1:INT_W];
            rem = wide[INT_W-1:0];
         end else begin
            rem = INT_W'(1);
         end
      end
   end
endmodule

// File: rtl/dbl2int_round.sv
module dbl2int_round
   import dbl2int_pkg::*;
#(
   parameter int INT_W = 64
) (
   input  logic [INT_W-1:0] mag,
   input  logic [INT_W-1:0] rem,
   input  logic             neg,
   input  rnd_mode_e        mode,
   input  logic             iovf,
   output logic [INT_W-1:0] result,
   output logic             inexact
);
   localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

   logic             frac_nz;
   logic             bump;
   logic [INT_W-1:0] rounded;

   always_comb begin
      frac_nz = (rem != '0);
      bump    = 1'b0;
      unique case (mode)
         RND_NEAR: bump = (rem == HALF) ? mag[0] : (rem > HALF);
         RND_UP:   bump = frac_nz && !neg;
         RND_DOWN: bump = frac_nz && neg;
         default:  bump = 1'b0;
      endcase
      rounded = mag + INT_W'(bump);
      result  = neg ? (~rounded + INT_W'(1)) : rounded;
      inexact = frac_nz || iovf;
   end
endmodule

// File: rtl/dbl2int_conv.sv
module dbl2int_conv
   import dbl2int_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 64,
   parameter int STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [EXP_W+FRAC_W:0] in_op,
   input  logic [1:0]            in_rmode,
   input  logic                  in_chop,
   input  logic                  in_ftz,
   output logic                  out_valid,
   output logic [INT_W-1:0]      out_result,
   output logic                  out_invalid,
   output logic                  out_iovf,
   output logic                  out_inexact
);
   if (STAGES < 1 || STAGES > 2) begin : g_bad_stages
      $error("dbl2int_conv: STAGES must be 1 or 2");
   end
   if (INT_W <= FRAC_W + 1) begin : g_bad_int_w
      $error("dbl2int_conv: INT_W must exceed the significand width");
   end
   if (EXP_W < 3) begin : g_bad_exp_w
      $error("dbl2int_conv: EXP_W too small");
   end

   logic [INT_W-1:0] a_mag, a_rem;
   logic             a_neg, a_inv, a_iov;
   rnd_mode_e        a_mode;

   logic [INT_W-1:0] s_mag, s_rem;
   logic             s_neg, s_inv, s_iov, s_vld;
   rnd_mode_e        s_mode;

   logic [INT_W-1:0] r_result;
   logic             r_inexact;

   assign a_mode = pick_mode(in_rmode, in_chop);

   dbl2int_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
      .op(in_op), .ftz(in_ftz), .mag(a_mag), .rem(a_rem),
      .neg(a_neg), .invalid(a_inv), .iovf(a_iov)
   );

   if (STAGES == 2) begin : g_split
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_vld  <= 1'b0;
            s_mag  <= '0;
            s_rem  <= '0;
            s_neg  <= 1'b0;
            s_inv  <= 1'b0;
            s_iov  <= 1'b0;
            s_mode <= RND_ZERO;
         end else begin
            s_vld <= in_valid;
            if (in_valid) begin
               s_mag  <= a_mag;
               s_rem  <= a_rem;
               s_neg  <= a_neg;
               s_inv  <= a_inv;
               s_iov  <= a_iov;
               s_mode <= a_mode;
            end
         end
      end
   end else begin : g_flat
      assign s_vld  = in_valid;
      assign s_mag  = a_mag;
      assign s_rem  = a_rem;
      assign s_neg  = a_neg;
      assign s_inv  = a_inv;
      assign s_iov  = a_iov;
      assign s_mode = a_mode;
   end

   dbl2int_round #(.INT_W(INT_W)) u_round (
      .mag(s_mag), .rem(s_rem), .neg(s_neg), .mode(s_mode),
      .iovf(s_iov), .result(r_result), .inexact(r_inexact)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_invalid <= 1'b0;
         out_iovf    <= 1'b0;
         out_inexact <= 1'b0;
      end else begin
         out_valid <= s_vld;
         if (s_vld) begin
            out_result  <= r_result;
            out_invalid <= s_inv;
            out_iovf    <= s_iov;
            out_inexact <= r_inexact;
         end
      end
   end

   p_invalid_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> (out_result == '0 && !out_iovf && !out_inexact));

   p_iovf_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_iovf) |-> out_inexact);

   p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_result) && $stable(out_inexact)));

   if (STAGES == 2) begin : g_lat2
      p_done_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> ##1 out_valid);
      p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ##1 !out_valid);
   end else begin : g_lat1
      p_done_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
   end
endmodule

// File: tb/tb_dbl2int_conv.sv
`timescale 1ns/1ps
module tb_dbl2int_conv;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_op = '0;
   logic [1:0]  in_rmode = '0;
   logic        in_chop = 1'b0;
   logic        in_ftz = 1'b0;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_invalid, out_iovf, out_inexact;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dbl2int_conv #(.STAGES(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_rmode(in_rmode), .in_chop(in_chop), .in_ftz(in_ftz),
      .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
      .out_iovf(out_iovf), .out_inexact(out_inexact)
   );

   function automatic void model(input logic [63:0] a, input logic [1:0] md, input logic ch,
                                 input logic fz, output logic [63:0] r, output logic iv,
                                 output logic ov, output logic ix);
      logic [63:0] fr, ret, rnd;
      int e, sh;
      logic s;
      logic [1:0] m;
      m = ch ? 2'd0 : md;
      s = a[63];
      e = int'(a[62:52]);
      fr = {12'b0, a[51:0]};
      ret = '0; rnd = '0; iv = 0; ov = 0; ix = 0;
      if (e == 0) begin
         if (fr != 0 && !fz) rnd = 64'd1;
      end else if (e == 2047) begin
         iv = 1;
      end else begin
         fr[52] = 1'b1;
         sh = e - 1075;
         if (sh >= 0) begin
            if (sh < 64) ret = fr << sh;
            if (sh >= 11 && a != 64'hC3E0000000000000) begin ov = 1; ix = 1; end
         end else begin
            sh = -sh;
            if (sh < 63) begin ret = fr >> sh; rnd = fr << (64 - sh); end
            else rnd = 64'd1;
         end
      end
      if (rnd != 0) begin
         ix = 1;
         case (m)
            2'd2: if (rnd == 64'h8000000000000000) ret = ret + {63'b0, ret[0]};
                  else if (rnd > 64'h8000000000000000) ret = ret + 1;
            2'd3: if (!s) ret = ret + 1;
            2'd1: if (s) ret = ret + 1;
            default: ;
         endcase
      end
      if (s) ret = -ret;
      r = ret;
   endfunction

   task automatic run_op(input logic [63:0] a, input logic [1:0] md, input logic ch,
                         input logic fz, input logic [63:0] er, input logic eiv,
                         input logic eov, input logic eix, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_op = a; in_rmode = md; in_chop = ch; in_ftz = fz;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 1; k < LAT; k++) @(negedge clk);
      total++;
      if (!out_valid || out_result !== er || out_invalid !== eiv || out_iovf !== eov ||
          out_inexact !== eix) begin
         bad++;
         $display("FAIL %s op=%h mode=%0d chop=%0b ftz=%0b: got v=%0b r=%h iv=%0b ov=%0b ix=%0b exp v=1 r=%h iv=%0b ov=%0b ix=%0b",
                  tag, a, md, ch, fz, out_valid, out_result, out_invalid, out_iovf, out_inexact,
                  er, eiv, eov, eix);
      end
   endtask

   task automatic check_bit(input logic got, input logic exp, input string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog expired got=hang exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] r;
      logic iv, ov, ix;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check_bit(out_valid, 1'b0, "R11 reset valid");
      total++;
      if (out_result !== 64'd0) begin
         bad++; $display("FAIL R11 reset result got=%h exp=0", out_result);
      end
      rst_n = 1'b1;

      // R11: done latency trace
      @(negedge clk);
      in_valid = 1'b1; in_op = 64'h3FF0000000000000; in_rmode = 2'd0;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 1; k <= LAT + 1; k++) begin
         check_bit(out_valid, k == LAT, "R11 latency");
         if (k < LAT + 1) @(negedge clk);
      end

      run_op(64'h3FF0000000000000, 2'd2, 0, 0, 64'd1, 0, 0, 0, "R4 one");
      run_op(64'hBFF0000000000000, 2'd2, 0, 0, 64'hFFFFFFFFFFFFFFFF, 0, 0, 0, "R9 minus one");
      run_op(64'h4004000000000000, 2'd2, 0, 0, 64'd2, 0, 0, 1, "R7 2.5 tie even");
      run_op(64'h400C000000000000, 2'd2, 0, 0, 64'd4, 0, 0, 1, "R7 3.5 tie odd");
      run_op(64'h3FE0000000000000, 2'd2, 0, 0, 64'd0, 0, 0, 1, "R7 0.5");
      run_op(64'h3FE8000000000000, 2'd2, 0, 0, 64'd1, 0, 0, 1, "R7 0.75");
      run_op(64'h3FF8000000000000, 2'd2, 0, 0, 64'd2, 0, 0, 1, "R7 1.5");
      run_op(64'h4004000000000000, 2'd3, 0, 0, 64'd3, 0, 0, 1, "R8 up positive");
      run_op(64'hC004000000000000, 2'd3, 0, 0, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1, "R8 up negative");
      run_op(64'hC004000000000000, 2'd1, 0, 0, 64'hFFFFFFFFFFFFFFFD, 0, 0, 1, "R8 down negative");
      run_op(64'hC004000000000000, 2'd0, 0, 0, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1, "R8 zero negative");
      run_op(64'h4004000000000000, 2'd3, 1, 0, 64'd2, 0, 0, 1, "R10 chop overrides up");
      run_op(64'hC004000000000000, 2'd1, 1, 0, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1, "R10 chop overrides down");
      run_op(64'h7FF8000000000000, 2'd2, 0, 0, 64'd0, 1, 0, 0, "R1 NaN");
      run_op(64'hFFF0000000000000, 2'd3, 0, 0, 64'd0, 1, 0, 0, "R1 minus inf");
      run_op(64'h0000000000000001, 2'd3, 0, 0, 64'd1, 0, 0, 1, "R2 subnormal up");
      run_op(64'h0000000000000001, 2'd2, 0, 0, 64'd0, 0, 0, 1, "R2 subnormal near");
      run_op(64'h8000000000000001, 2'd1, 0, 0, 64'hFFFFFFFFFFFFFFFF, 0, 0, 1, "R2 subnormal down");
      run_op(64'h0000000000000001, 2'd3, 0, 1, 64'd0, 0, 0, 0, "R3 flush");
      run_op(64'h8000000000000000, 2'd1, 0, 0, 64'd0, 0, 0, 0, "R3 true zero");
      run_op(64'h0010000000000000, 2'd3, 0, 0, 64'd1, 0, 0, 1, "R6 tiny normal sticky");
      run_op(64'h4330000000000000, 2'd2, 0, 0, 64'h0010000000000000, 0, 0, 0, "R4 shift zero");
      run_op(64'h43DFFFFFFFFFFFFF, 2'd2, 0, 0, 64'h7FFFFFFFFFFFFC00, 0, 0, 0, "R5 below limit");
      run_op(64'h43E0000000000000, 2'd2, 0, 0, 64'h8000000000000000, 0, 1, 1, "R5 two pow 63");
      run_op(64'hC3E0000000000000, 2'd2, 0, 0, 64'h8000000000000000, 0, 0, 0, "R5 minus two pow 63");
      run_op(64'h43F0000000000000, 2'd2, 0, 0, 64'd0, 0, 1, 1, "R4 two pow 64 wraps");

      for (int n = 0; n < 400; n++) begin
         logic [63:0] a;
         logic [1:0] md;
         logic ch, fz;
         int e;
         a = {$urandom, $urandom};
         case ($urandom_range(0, 9))
            0: e = 0;
            1: e = 2047;
            2: e = $urandom_range(1, 960);
            default: e = $urandom_range(1010, 1140);
         endcase
         a[62:52] = e[10:0];
         md = 2'($urandom_range(0, 3));
         ch = ($urandom_range(0, 7) == 0);
         fz = $urandom_range(0, 1) == 1;
         model(a, md, ch, fz, r, iv, ov, ix);
         run_op(a, md, ch, fz, r, iv, ov, ix, "R6 R7 R8 R9 random");
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule